// File: doc/BRIEF.md
# Privileged Trap Entry and Return Unit

This unit steers the program counter into and out of a privileged handler mode. When a fault, trap or interrupt arrives, it computes the handler vector as a handler base plus a fixed offset for the cause. It also decides which restart address to save. Entering the handler from normal mode swaps a fixed group of integer registers with their shadow copies. A return-from-exception request loads the program counter from the saved address. When bit 0 of that address is clear, the return also swaps the shadow group back out. The register storage lives elsewhere; this unit only emits a per-register swap strobe.

Bit 0 of the program counter is the mode indicator: 1 means handler mode and 0 means normal mode. Every vector offset is odd, so every vector lands in handler mode. A small state machine tracks which register bank is live. It has three states:

- `SH_BOOT`: the state held during reset.
- `SH_ACTIVE`: the shadow set is swapped in.
- `SH_PRIMARY`: the shadow set is swapped out.

The transitions are:

- **boot**: `SH_BOOT` to `SH_ACTIVE`, on the first clock after reset, with a swap-in.
- **swap-out**: `SH_ACTIVE` to `SH_PRIMARY`, on a return whose saved address has bit 0 clear.
- **swap-in**: `SH_PRIMARY` to `SH_ACTIVE`, on an entry from normal mode.
- **refused swap**: a request to swap into the bank that is already live leaves the state unchanged and pulses an error.

All outputs are registered. An input sampled at one rising edge shows its effect on the outputs right after that edge.

Top module: `trap_unit`

## Requirements
- R1: While reset is asserted, `next_pc`, `saved_pc` and `swap_regs` read 0, and `swap_in`, `swap_err` and `shadow_active` read 0. On the first clock after reset, all inputs are ignored. On that clock, `next_pc` becomes `hbase + 0x0001`, `swap_regs` pulses with the shadow mask while `swap_in` reads 1, and `shadow_active` becomes 1.
- R2: An event (`ev_valid`=1) jumps to `hbase` plus the offset for `ev_cause`. The offsets are: code 0 interrupt 0x0101, code 1 machine check 0x0401, code 2 arithmetic 0x0501, code 3 alignment 0x0301, code 4 unimplemented opcode 0x0481, code 5 handler call 0x2001.
- R3: On an event, `saved_pc` becomes `cur_pc + 4` for the trap-class codes 2 and 5. For every other code it becomes `cur_pc`.
- R4: An interrupt (code 0) taken while `cur_pc[0]`=1 leaves `saved_pc` unchanged.
- R5: The swap mask is 0x02007F00, covering registers 8 to 14 and register 25.
  - An entry while `cur_pc[0]`=0 pulses `swap_regs` with this mask and `swap_in`=1.
  - An entry while `cur_pc[0]`=1 performs no swap.
  - On every cycle without a swap, `swap_regs` and `swap_in` read 0.
- R6: A return (`ret_req`=1, `ev_valid`=0) while `cur_pc[0]`=1 sets `next_pc` to `saved_pc`. If bit 0 of `saved_pc` is 0, the return also pulses `swap_regs` with the mask and `swap_in`=0, and clears `shadow_active`.
- R7: A return while `cur_pc[0]`=0 is treated as an unimplemented-opcode entry (code 4): it jumps to `hbase + 0x0481`, saves `cur_pc`, and follows R5.
- R8: With no event and no return, `next_pc` is `cur_pc + 4`. Codes 6 and 7 are ignored as if `ev_valid` were 0. An event takes priority over a simultaneous return.
- R9: A swap into the bank that is already live is refused. A swap-in while `shadow_active`=1, or a swap-out while it is 0, pulses `swap_err`, leaves `swap_regs` at 0 and leaves `shadow_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Fault, trap or interrupt request |
| ev_cause | input | 3 | Cause code of the event |
| ret_req | input | 1 | Return-from-exception request |
| cur_pc | input | AW | Current program counter; bit 0 is the mode indicator |
| hbase | input | AW | Handler base address |
| next_pc | output | AW | Next program counter |
| saved_pc | output | AW | Saved restart address |
| swap_regs | output | NREG | Per-register shadow swap strobe |
| swap_in | output | 1 | The swap in progress brings the shadow set in |
| swap_err | output | 1 | Refused swap request |
| shadow_active | output | 1 | The shadow set is live |

## Verification
The assertions check on every cycle that:

- a return restores the saved address;
- an interrupt nested in handler mode keeps the saved address;
- trap-class entries save the skipped-ahead address;
- the boot vector is correct;
- a swap-in always leaves the shadow bank live;
- a refused swap never moves the bank state.

Only the bench's scenarios can show the complete per-cause offset table, the exact swap mask, and the refused swap. A refused swap needs a deliberate mismatch between the program-counter mode bit and the live bank. These scenarios also exercise returns whose saved address has bit 0 set, which must stay in handler mode without swapping.

// File: rtl/trap_unit_pkg.sv
package trap_unit_pkg;

    typedef enum logic [2:0] {
        CAUSE_INTR  = 3'd0,
        CAUSE_MCHK  = 3'd1,
        CAUSE_ARITH = 3'd2,
        CAUSE_ALIGN = 3'd3,
        CAUSE_UNIMP = 3'd4,
        CAUSE_CALL  = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        SH_BOOT    = 2'd0,
        SH_PRIMARY = 2'd1,
        SH_ACTIVE  = 2'd2
    } shadow_st_e;

    localparam logic [15:0] RESET_OFS = 16'h0001;
    localparam int unsigned OFS_W     = 16;

    // Per-cause handler offset; bit 0 set so the vector enters handler mode.
    function automatic logic [15:0] vec_ofs(input cause_e c);
        logic [15:0] o;
        unique case (c)
            CAUSE_INTR:  o = 16'h0101;
            CAUSE_MCHK:  o = 16'h0401;
            CAUSE_ARITH: o = 16'h0501;
            CAUSE_ALIGN: o = 16'h0301;
            CAUSE_UNIMP: o = 16'h0481;
            CAUSE_CALL:  o = 16'h2001;
            default:     o = 16'h0481;
        endcase
        return o;
    endfunction

    // Traps resume after the instruction that raised them.
    function automatic logic skips_ahead(input cause_e c);
        return (c == CAUSE_ARITH) || (c == CAUSE_CALL);
    endfunction

    function automatic logic cause_known(input logic [2:0] c);
        return c <= 3'd5;
    endfunction

endpackage

// File: rtl/trap_vector.sv
module trap_vector
    import trap_unit_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] base,
    input  cause_e        cause,
    input  logic          boot,
    output logic [AW-1:0] vec
);
    localparam int unsigned PADW = AW - OFS_W;

    logic [15:0] ofs;

    always_comb begin
        ofs = boot ? RESET_OFS : vec_ofs(cause);
        vec = base + {{PADW{1'b0}}, ofs};
    end
endmodule

// File: rtl/trap_restart.sv
module trap_restart
    import trap_unit_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc,
    input  cause_e        cause,
    input  logic          hmode,
    input  logic          take,
    input  logic [AW-1:0] old_save,
    output logic [AW-1:0] new_save
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(4);

    logic keep;

    always_comb begin
        // A nested interrupt must not clobber the outer restart point.
        keep = (cause == CAUSE_INTR) && hmode;
        if (!take || keep)
            new_save = old_save;
        else if (skips_ahead(cause))
            new_save = pc + INSN_BYTES;
        else
            new_save = pc;
    end
endmodule

// File: rtl/shadow_ctl.sv
module shadow_ctl
    import trap_unit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic req_out,
    output logic boot,
    output logic active,
    output logic pulse,
    output logic dir_in,
    output logic err
);
    shadow_st_e st_q, st_nx;
    logic       pulse_d, dir_d, err_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SH_BOOT;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx   = st_q;
        pulse_d = 1'b0;
        dir_d   = 1'b0;
        err_d   = 1'b0;
        unique case (st_q)
            SH_BOOT: begin
                st_nx   = SH_ACTIVE;
                pulse_d = 1'b1;
                dir_d   = 1'b1;
            end
            SH_ACTIVE: begin
                if (req_out) begin
                    st_nx   = SH_PRIMARY;
                    pulse_d = 1'b1;
                end else if (req_in) begin
                    err_d = 1'b1;
                end
            end
            SH_PRIMARY: begin
                if (req_in) begin
                    st_nx   = SH_ACTIVE;
                    pulse_d = 1'b1;
                    dir_d   = 1'b1;
                end else if (req_out) begin
                    err_d = 1'b1;
                end
            end
            default: st_nx = SH_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            dir_in <= 1'b0;
            err    <= 1'b0;
        end else begin
            pulse  <= pulse_d;
            dir_in <= dir_d;
            err    <= err_d;
        end
    end

    assign boot   = (st_q == SH_BOOT);
    assign active = (st_q == SH_ACTIVE);

    assert_swapin_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && dir_in) |-> (st_q == SH_ACTIVE));

    assert_refused_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in && st_q == SH_ACTIVE) |=> (err && st_q == SH_ACTIVE));
endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_unit_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned NREG     = 32,
    parameter int unsigned SH_LO    = 8,
    parameter int unsigned SH_HI    = 14,
    parameter int unsigned SH_EXTRA = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_valid,
    input  logic [2:0]      ev_cause,
    input  logic            ret_req,
    input  logic [AW-1:0]   cur_pc,
    input  logic [AW-1:0]   hbase,
    output logic [AW-1:0]   next_pc,
    output logic [AW-1:0]   saved_pc,
    output logic [NREG-1:0] swap_regs,
    output logic            swap_in,
    output logic            swap_err,
    output logic            shadow_active
);
    function automatic logic [NREG-1:0] build_mask();
        logic [NREG-1:0] m;
        m = '0;
        for (int i = 0; i < int'(NREG); i++)
            if ((i >= int'(SH_LO) && i <= int'(SH_HI)) || i == int'(SH_EXTRA))
                m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NREG-1:0] SHADOW_MASK = build_mask();
    localparam logic [AW-1:0]   INSN_BYTES  = AW'(4);

    logic            hmode, ev_ok, ret_bad, take, do_ret, boot;
    logic            req_in, req_out, pulse, dir_in;
    cause_e          eff_cause;
    logic [AW-1:0]   vec, save_d, npc_d;
    logic [AW-1:0]   npc_q, exc_q;

    always_comb begin
        hmode     = cur_pc[0];
        ev_ok     = ev_valid && cause_known(ev_cause);
        ret_bad   = ret_req && !hmode && !ev_ok;
        take      = !boot && (ev_ok || ret_bad);
        do_ret    = !boot && ret_req && hmode && !ev_ok;
        eff_cause = ev_ok ? cause_e'(ev_cause) : CAUSE_UNIMP;
        req_in    = take && !hmode;
        req_out   = do_ret && !exc_q[0];
    end

    trap_vector #(.AW(AW)) u_vec (
        .base  (hbase),
        .cause (eff_cause),
        .boot  (boot),
        .vec   (vec)
    );

    trap_restart #(.AW(AW)) u_rst (
        .pc       (cur_pc),
        .cause    (eff_cause),
        .hmode    (hmode),
        .take     (take),
        .old_save (exc_q),
        .new_save (save_d)
    );

    shadow_ctl u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .req_out (req_out),
        .boot    (boot),
        .active  (shadow_active),
        .pulse   (pulse),
        .dir_in  (dir_in),
        .err     (swap_err)
    );

    always_comb begin
        if (boot || take) npc_d = vec;
        else if (do_ret)  npc_d = exc_q;
        else              npc_d = cur_pc + INSN_BYTES;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_q <= '0;
            exc_q <= '0;
        end else begin
            npc_q <= npc_d;
            exc_q <= save_d;
        end
    end

    assign next_pc   = npc_q;
    assign saved_pc  = exc_q;
    assign swap_regs = pulse ? SHADOW_MASK : '0;
    assign swap_in   = pulse && dir_in;

    assert_boot_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        boot |=> (next_pc == $past(hbase) + AW'(1)));

    assert_trap_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && skips_ahead(eff_cause)) |=> (saved_pc == $past(cur_pc) + INSN_BYTES));

    assert_nested_intr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && eff_cause == CAUSE_INTR && hmode) |=> (saved_pc == $past(saved_pc)));

    assert_ret_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (next_pc == $past(saved_pc)));
endmodule

// File: tb/trap_unit_tb.sv
module trap_unit_tb;
    localparam int AW = 32;
    localparam logic [31:0] MASK = 32'h02007F00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [2:0]    ev_cause = 3'd0;
    logic          ret_req = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic [AW-1:0] hbase = 32'h0001_0000;
    logic [AW-1:0] next_pc, saved_pc;
    logic [31:0]   swap_regs;
    logic          swap_in, swap_err, shadow_active;

    int errors = 0;
    int checks = 0;

    // reference state
    logic          m_shadow;
    logic [AW-1:0] m_exc;

    always #2 clk = ~clk;

    trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_cause(ev_cause),
        .ret_req(ret_req), .cur_pc(cur_pc), .hbase(hbase), .next_pc(next_pc),
        .saved_pc(saved_pc), .swap_regs(swap_regs), .swap_in(swap_in),
        .swap_err(swap_err), .shadow_active(shadow_active)
    );

    function automatic logic [AW-1:0] ofs_of(input logic [2:0] c);
        case (c)
            3'd0: return 32'h0101;
            3'd1: return 32'h0401;
            3'd2: return 32'h0501;
            3'd3: return 32'h0301;
            3'd4: return 32'h0481;
            default: return 32'h2001;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic ev, input logic [2:0] c, input logic rt,
                        input logic [AW-1:0] pc, input logic [AW-1:0] base);
        logic hm, evok, retbad, take, doret, rin, rout;
        logic [2:0] ec;
        logic [AW-1:0] e_npc, e_exc;
        logic [31:0] e_sw;
        logic e_in, e_err;
        string t_npc, t_exc, t_sw;
        ev_valid = ev; ev_cause = c; ret_req = rt; cur_pc = pc; hbase = base;
        hm = pc[0];
        evok = ev && (c <= 3'd5);
        retbad = rt && !hm && !evok;
        take = evok || retbad;
        doret = rt && hm && !evok;
        ec = evok ? c : 3'd4;
        if (take) begin
            e_npc = base + ofs_of(ec);
            t_npc = retbad ? "R7" : "R2";
        end else if (doret) begin
            e_npc = m_exc; t_npc = "R6";
        end else begin
            e_npc = pc + 4; t_npc = "R8";
        end
        e_exc = m_exc; t_exc = "R3";
        if (take) begin
            if (ec == 3'd0 && hm) t_exc = "R4";
            else e_exc = (ec == 3'd2 || ec == 3'd5) ? pc + 4 : pc;
        end
        rin = take && !hm;
        rout = doret && !m_exc[0];
        e_sw = '0; e_in = 1'b0; e_err = 1'b0; t_sw = "R5";
        if (rin) begin
            if (!m_shadow) begin e_sw = MASK; e_in = 1'b1; m_shadow = 1'b1; end
            else begin e_err = 1'b1; t_sw = "R9"; end
        end else if (rout) begin
            t_sw = "R6";
            if (m_shadow) begin e_sw = MASK; m_shadow = 1'b0; end
            else begin e_err = 1'b1; t_sw = "R9"; end
        end
        m_exc = e_exc;
        @(posedge clk); #1;
        chk(t_npc, "next_pc", next_pc, e_npc);
        chk(t_exc, "saved_pc", saved_pc, e_exc);
        chk(t_sw, "swap_regs", swap_regs, e_sw);
        chk(t_sw, "swap_in", 32'(swap_in), 32'(e_in));
        chk("R9", "swap_err", 32'(swap_err), 32'(e_err));
        chk(t_sw, "shadow_active", 32'(shadow_active), 32'(m_shadow));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset next_pc", next_pc, 0);
        chk("R1", "reset swap_regs", swap_regs, 0);
        chk("R1", "reset shadow_active", 32'(shadow_active), 0);
        chk("R1", "reset swap_err", 32'(swap_err), 0);
        // R1: boot cycle ignores inputs
        ev_valid = 1'b1; ev_cause = 3'd5; ret_req = 1'b1; cur_pc = 32'h40;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "boot next_pc", next_pc, 32'h0001_0001);
        chk("R1", "boot swap_regs", swap_regs, MASK);
        chk("R1", "boot swap_in", 32'(swap_in), 1);
        chk("R1", "boot shadow_active", 32'(shadow_active), 1);
        chk("R1", "boot saved_pc", saved_pc, 0);
        m_shadow = 1'b1; m_exc = '0;

        // directed: return in handler to even saved address 0 -> swap out (R6)
        step(1'b0, 3'd0, 1'b1, 32'h0001_0005, 32'h0001_0000);
        // R8 idle, and ignored codes 6/7
        step(1'b0, 3'd0, 1'b0, 32'h0000_1000, 32'h0001_0000);
        step(1'b1, 3'd6, 1'b0, 32'h0000_1004, 32'h0001_0000);
        step(1'b1, 3'd7, 1'b0, 32'h0000_1008, 32'h0001_0000);
        // R2/R3/R5: handler call from normal mode, swaps in
        step(1'b1, 3'd5, 1'b0, 32'h0000_2000, 32'h0002_0000);
        // R4: nested interrupt in handler mode keeps saved address
        step(1'b1, 3'd0, 1'b0, 32'h0002_2001, 32'h0002_0000);
        // R8 priority: event with a return at the same time
        step(1'b1, 3'd3, 1'b1, 32'h0002_0301, 32'h0002_0000);
        // R9: entry from normal mode while shadow already live
        step(1'b1, 3'd1, 1'b0, 32'h0000_3000, 32'h0003_0000);
        // R6: return leaves handler mode
        step(1'b0, 3'd0, 1'b1, 32'h0003_0401, 32'h0003_0000);
        // R7: return issued in normal mode
        step(1'b0, 3'd0, 1'b1, 32'h0000_3000, 32'h0003_0000);
        // R9: forced swap-out while primary: enter from handler with even restart
        step(1'b0, 3'd0, 1'b1, 32'h0003_0481, 32'h0003_0000);
        step(1'b0, 3'd0, 1'b1, 32'h0000_3001, 32'h0003_0000);
        step(1'b1, 3'd2, 1'b0, 32'h0000_5001, 32'h0003_0000);
        step(1'b0, 3'd0, 1'b1, 32'h0003_0501, 32'h0003_0000);

        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] pc, b;
            logic [2:0] c;
            logic ev, rt;
            pc = $urandom();
            b  = $urandom() & 32'hFFFF_0000;
            c  = 3'($urandom_range(0, 7));
            ev = ($urandom_range(0, 2) == 0);
            rt = ($urandom_range(0, 2) == 0);
            step(ev, c, rt, pc, b);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule